// File: doc/BRIEF.md
# Synchronous DRAM Burst Data Path with Clock Suspend and Byte Masking

This block is the device-side column data path of one synchronous DRAM bank. It accepts read and write commands with a starting column. It walks that column through either a four-beat burst or an open-ended page burst. It moves data between a small register array and the pins. Read data leaves through a pipeline whose depth is set by the CAS latency input. A per-lane output enable tells the pad ring when to drive and when to leave the bus at high impedance.

A registered clock-enable input gates an internal clock tick. Lowering it freezes the burst counter, the read pipeline and the mask pipeline one cycle later. A per-byte data-mask input applies to both directions, with a different delay for each. For writes it blocks the byte lanes of the beat it is sampled with. For reads it blanks the lanes two internal clocks later. In both directions the burst keeps advancing past a masked beat. Activation, precharge, refresh and multi-bank control are left to the surrounding logic.

Top module: `sdram_burst_path`

## Requirements
- R1: A cycle with `rst` high clears the array to zero, drives `rdata_oe` and `rdata` to zero on the next cycle, and makes the clock enable read as high.
- R2: With `page_mode` low, a burst has four beats. Each beat's column increments by one inside the aligned four-column group: the low two bits wrap, and the upper bits stay as given.
- R3: With `page_mode` high at the command, the burst increments the column modulo the column count (15 wraps to 0). It continues until a STOP or a new READ or WRITE command.
- R4: A READ taken on internal tick 0 has its first word on `rdata` after internal tick CL-1, so the host samples it on tick CL. `cas_lat3`=0 selects CL=2 and `cas_lat3`=1 selects CL=3.
- R5: `cke` sampled low on a rising edge suppresses the internal tick on the next edge. `cke` sampled high on an edge restores the tick on the next edge.
- R6: While the tick is suppressed, no command is taken and the column does not advance. `rdata` and `rdata_oe` hold their values, and nothing is written.
- R7: A `dqm` lane bit that is high on the tick of a write beat leaves that byte of the addressed word unchanged. The burst still moves to the next column.
- R8: A `dqm` lane bit that is high on internal tick n drives that lane's `rdata_oe` bit low, and its `rdata` byte to zero, for the word presented after tick n+1. The read burst still advances.
- R9: When no read word is due, `rdata_oe` is all zero and `rdata` is zero. The bits of `rdata` in a lane with a low enable bit are always zero.
- R10: Command codes on `cmd`: 00 NOP, 01 READ, 10 WRITE, 11 STOP. A STOP issues no beat and ends the burst. A new READ or WRITE ends the running burst and starts its own on the same tick.
- R11: The tick that takes a WRITE also writes its first beat from `wdata` to the start column. Each later tick of the burst writes the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code: NOP, READ, WRITE or STOP |
| col | input | COL_W (4) | Start column, taken with READ or WRITE |
| page_mode | input | 1 | 1 selects an open-ended page burst for this command |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects latency 2 |
| cke | input | 1 | Clock enable, registered before it gates the internal tick |
| dqm | input | LANES (2) | Per-byte data mask for both directions |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data, zero in lanes that are not enabled |
| rdata_oe | output | LANES (2) | Per-lane output enable; 0 means high impedance |

## Verification
The bench builds the block with its default parameters: 16 columns of 16 bits, two byte lanes, and burst length 4. At this size the page burst can cross the 15-to-0 column wrap in a few beats. Each of the two lanes can be masked on its own. A four-beat burst that starts in mid-group reaches the aligned wrap. Both latencies are run against the same clock-enable and mask sequences. This shows how the read-mask delay and the frozen tick interact at every pipeline depth the block offers.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_STOP  = 2'b11
    } cmd_e;

    localparam int LANE_W = 8;

    // Column that follows cur in a burst: aligned wrap for fixed bursts,
    // modulo the column count for page bursts.
    function automatic int unsigned step_col(input int unsigned cur,
                                             input int unsigned cols,
                                             input int unsigned blen,
                                             input logic        page);
        int unsigned base;
        if (page) begin
            return (cur + 1) % cols;
        end
        base = (cur / blen) * blen;
        return base + ((cur + 1) % blen);
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/sdram_cke_sync.sv
module sdram_cke_sync (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic tick
);
    // The internal clock runs on an edge only if cke was high on the edge before.
    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= 1'b1;
        end else begin
            tick <= cke;
        end
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_dp_pkg::*;
#(
    parameter int COLS      = 16,
    parameter int BURST_LEN = 4,
    localparam int COL_W    = $clog2(COLS),
    localparam int CNT_W    = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cmd_e             cmd,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             page_mode,
    output logic             issue_valid,
    output logic             issue_write,
    output logic             issue_page,
    output logic [COL_W-1:0] issue_col
);
    logic             active_q;
    logic             write_q;
    logic             page_q;
    logic [COL_W-1:0] col_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;
    logic             cont;
    logic [COL_W-1:0] col_nxt;
    logic             last_beat;

    always_comb begin
        start       = tick && is_access(cmd);
        cont        = tick && active_q && (cmd == CMD_NOP);
        issue_valid = start || cont;
        issue_write = start ? (cmd == CMD_WRITE) : write_q;
        issue_page  = start ? page_mode : page_q;
        issue_col   = start ? cmd_col : col_q;
        col_nxt     = COL_W'(step_col(int'(unsigned'(issue_col)), COLS, BURST_LEN, issue_page));
        last_beat   = !page_q && (cnt_q == CNT_W'(BURST_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            write_q  <= 1'b0;
            page_q   <= 1'b0;
            col_q    <= '0;
            cnt_q    <= '0;
        end else if (tick) begin
            if (start) begin
                active_q <= 1'b1;
                write_q  <= (cmd == CMD_WRITE);
                page_q   <= page_mode;
                col_q    <= col_nxt;
                cnt_q    <= CNT_W'(1);
            end else if (cmd == CMD_STOP) begin
                active_q <= 1'b0;
            end else if (active_q) begin
                col_q <= col_nxt;
                cnt_q <= cnt_q + CNT_W'(1);
                if (last_beat) begin
                    active_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sdram_cell_array.sv
module sdram_cell_array
    import sdram_dp_pkg::*;
#(
    parameter int COLS   = 16,
    parameter int DATA_W = 16,
    localparam int COL_W = $clog2(COLS),
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_we,
    input  logic [COL_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells_q [COLS];

    assign rdata = cells_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COLS; i++) begin
                cells_q[i] <= '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l]) begin
                    cells_q[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
                end
            end
        end
    end
endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe
    import sdram_dp_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES  = DATA_W / LANE_W,
    localparam int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cas_lat3,
    input  logic [LANES-1:0]  dqm,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [LANES-1:0]  out_oe,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_beat_t;

    rd_beat_t          stg_q [STAGES];
    rd_beat_t          sel;
    logic [LANES-1:0]  dqm_q;
    logic [LANES-1:0]  lane_show;
    logic [DATA_W-1:0] byte_keep;

    // Latency chain: stage 0 holds the beat fetched on the last tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q[0] <= '0;
        end else if (tick) begin
            stg_q[0] <= '{valid: in_valid, data: in_data};
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q[s] <= '0;
            end else if (tick) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign sel       = cas_lat3 ? stg_q[STAGES-1] : stg_q[STAGES-2];
    assign lane_show = {LANES{sel.valid}} & ~dqm_q;

    for (genvar l = 0; l < LANES; l++) begin : g_keep
        assign byte_keep[l*LANE_W +: LANE_W] = {LANE_W{lane_show[l]}};
    end

    // Mask sampled on one tick acts on the word loaded at the next tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            dqm_q    <= '0;
            out_oe   <= '0;
            out_data <= '0;
        end else if (tick) begin
            dqm_q    <= dqm;
            out_oe   <= lane_show;
            out_data <= sel.data & byte_keep;
        end
    end
endmodule

// File: rtl/sdram_burst_path.sv
module sdram_burst_path
    import sdram_dp_pkg::*;
#(
    parameter int COLS      = 16,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    localparam int COL_W    = $clog2(COLS),
    localparam int LANES    = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [COL_W-1:0]  col,
    input  logic              page_mode,
    input  logic              cas_lat3,
    input  logic              cke,
    input  logic [LANES-1:0]  dqm,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rdata_oe
);
    cmd_e              cmd_t;
    logic              tick;
    logic              issue_valid;
    logic              issue_write;
    logic              issue_page;
    logic [COL_W-1:0]  issue_col;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] cell_rd;
    logic              rd_fetch;

    assign cmd_t = cmd_e'(cmd);

    sdram_cke_sync u_cke (
        .clk  (clk),
        .rst  (rst),
        .cke  (cke),
        .tick (tick)
    );

    sdram_burst_seq #(
        .COLS      (COLS),
        .BURST_LEN (BURST_LEN)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .cmd         (cmd_t),
        .cmd_col     (col),
        .page_mode   (page_mode),
        .issue_valid (issue_valid),
        .issue_write (issue_write),
        .issue_page  (issue_page),
        .issue_col   (issue_col)
    );

    // Write mask acts on the beat it arrives with.
    assign lane_we  = {LANES{issue_valid && issue_write}} & ~dqm;
    assign rd_fetch = issue_valid && !issue_write;

    sdram_cell_array #(
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk     (clk),
        .rst     (rst),
        .lane_we (lane_we),
        .addr    (issue_col),
        .wdata   (wdata),
        .rdata   (cell_rd)
    );

    sdram_read_pipe #(
        .DATA_W (DATA_W)
    ) u_rpipe (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cas_lat3 (cas_lat3),
        .dqm      (dqm),
        .in_valid (rd_fetch),
        .in_data  (cell_rd),
        .out_oe   (rdata_oe),
        .out_data (rdata)
    );
endmodule

// File: rtl/sdram_burst_path_chk.sv
module sdram_burst_path_chk
    import sdram_dp_pkg::*;
#(
    parameter int COLS      = 16,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    localparam int COL_W    = $clog2(COLS),
    localparam int BL_W     = $clog2(BURST_LEN),
    localparam int LANES    = DATA_W / LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic [LANES-1:0]  dqm,
    input cmd_e              cmd,
    input logic              tick,
    input logic              issue_valid,
    input logic              issue_page,
    input logic [COL_W-1:0]  issue_col,
    input logic [DATA_W-1:0] rdata,
    input logic [LANES-1:0]  rdata_oe
);
    logic [COL_W-1:0] prev_col;
    logic [COL_W-1:0] wrap_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_col <= '0;
        end else if (tick && issue_valid) begin
            prev_col <= issue_col;
        end
    end

    assign wrap_col = {prev_col[COL_W-1:BL_W], prev_col[BL_W-1:0] + BL_W'(1)};

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (rdata_oe == '0 && rdata == '0)); // R1

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && issue_valid && cmd == CMD_NOP && !issue_page) |-> issue_col == wrap_col); // R2

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cke |-> ##2 ($stable(rdata_oe) && $stable(rdata))); // R6

    AST_READ_MASK: assert property (@(posedge clk) disable iff (rst)
        (tick && dqm != '0) ##1 tick |=> ((rdata_oe & $past(dqm, 2)) == '0)); // R8

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (tick && cmd == CMD_STOP) |-> !issue_valid); // R10

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (tick && cmd == CMD_STOP) ##1 (cmd == CMD_NOP) |-> !issue_valid); // R10
endmodule

bind sdram_burst_path sdram_burst_path_chk #(
    .COLS      (COLS),
    .DATA_W    (DATA_W),
    .BURST_LEN (BURST_LEN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cke         (cke),
    .dqm         (dqm),
    .cmd         (cmd_t),
    .tick        (tick),
    .issue_valid (issue_valid),
    .issue_page  (issue_page),
    .issue_col   (issue_col),
    .rdata       (rdata),
    .rdata_oe    (rdata_oe)
);

// File: tb/tb_sdram_burst_path.sv
module tb_sdram_burst_path;
    localparam int COLS = 16;
    localparam int DW   = 16;
    localparam int LN   = 2;
    localparam int BL   = 4;

    localparam logic [1:0] NOP = 2'b00;
    localparam logic [1:0] RD  = 2'b01;
    localparam logic [1:0] WR  = 2'b10;
    localparam logic [1:0] STP = 2'b11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd = NOP;
    logic [3:0]    col = '0;
    logic          page_mode = 1'b0;
    logic          cas_lat3 = 1'b0;
    logic          cke = 1'b1;
    logic [LN-1:0] dqm = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [LN-1:0] rdata_oe;

    int checks = 0;
    int failures = 0;
    string phase = "R1";

    // reference model state
    logic [DW-1:0] mem_m [COLS];
    bit            cke_prev;
    int            ie;
    bit            m_active, m_write, m_page;
    int            m_col, m_cnt;
    logic [DW-1:0] pend [int];
    logic [LN-1:0] dqm_hist [int];
    logic [LN-1:0] exp_oe;
    logic [DW-1:0] exp_data;

    always #5 clk = ~clk;

    sdram_burst_path dut (
        .clk(clk), .rst(rst), .cmd(cmd), .col(col), .page_mode(page_mode),
        .cas_lat3(cas_lat3), .cke(cke), .dqm(dqm), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nextc(input int c, input bit pg);
        if (pg) return (c + 1) % COLS;
        return (c / BL) * BL + ((c + 1) % BL);
    endfunction

    task automatic model_edge();
        bit tk;
        bit iv, iw;
        int ic;
        logic [LN-1:0] m;
        tk = cke_prev;
        cke_prev = cke;
        if (!tk) return;
        ie++;
        dqm_hist[ie] = dqm;
        iv = 0; iw = 0; ic = 0;
        if (cmd == RD || cmd == WR) begin
            iv = 1; iw = (cmd == WR); ic = col;
            m_active = 1; m_write = iw; m_page = page_mode; m_cnt = 1;
            m_col = nextc(ic, m_page);
        end else if (cmd == STP) begin
            m_active = 0;
        end else if (m_active) begin
            iv = 1; iw = m_write; ic = m_col;
            m_col = nextc(ic, m_page);
            m_cnt++;
            if (!m_page && m_cnt == BL) m_active = 0;
        end
        if (iv && iw) begin
            for (int l = 0; l < LN; l++)
                if (!dqm[l]) mem_m[ic][l*8 +: 8] = wdata[l*8 +: 8];
        end
        if (iv && !iw) pend[ie + (cas_lat3 ? 3 : 2) - 1] = mem_m[ic];
        if (pend.exists(ie)) begin
            m = dqm_hist.exists(ie - 1) ? dqm_hist[ie - 1] : '0;
            exp_oe = ~m;
            exp_data = '0;
            for (int l = 0; l < LN; l++)
                if (!m[l]) exp_data[l*8 +: 8] = pend[ie][l*8 +: 8];
        end else begin
            exp_oe = '0;
            exp_data = '0;
        end
    endtask

    task automatic cyc(input logic [1:0] c, input int cc, input bit pg,
                       input bit ck, input logic [LN-1:0] dq, input logic [DW-1:0] wd);
        cmd = c; col = 4'(cc); page_mode = pg; cke = ck; dqm = dq; wdata = wd;
        @(posedge clk);
        model_edge();
        #1;
        check({phase, " oe"}, rdata_oe === exp_oe, 32'(rdata_oe), 32'(exp_oe));
        check({phase, " data"}, rdata === exp_data, 32'(rdata), 32'(exp_data));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(NOP, 0, 0, 1, '0, '0);
    endtask

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < COLS; i++) mem_m[i] = '0;
        cke_prev = 1; ie = 0; m_active = 0; m_write = 0; m_page = 0; m_col = 0; m_cnt = 0;
        exp_oe = '0; exp_data = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset oe", rdata_oe === '0, 32'(rdata_oe), 0);
        check("R1 reset data", rdata === '0, 32'(rdata), 0);
        rst = 1'b0;

        // R1: unwritten column reads zero
        phase = "R1 R4";
        cyc(RD, 8, 0, 1, '0, '0); idle(5);

        // R11 R7 R9: write burst from mid-group with masked lanes, no output enable
        phase = "R7 R9 R11";
        cyc(WR, 5, 0, 1, 2'b00, 16'hA0A1);
        cyc(NOP, 0, 0, 1, 2'b11, 16'hB0B1);
        cyc(NOP, 0, 0, 1, 2'b10, 16'hC0C1);
        cyc(NOP, 0, 0, 1, 2'b01, 16'hD0D1);
        idle(3);

        // R2 R4: wrapped readback at both latencies
        phase = "R2 R4 CL2";
        cas_lat3 = 0; cyc(RD, 4, 0, 1, '0, '0); idle(5);
        phase = "R2 R4 CL3";
        cas_lat3 = 1; cyc(RD, 6, 0, 1, '0, '0); idle(6);

        // R8: read mask two ticks later
        phase = "R8";
        cas_lat3 = 0;
        cyc(RD, 4, 0, 1, 2'b01, '0); cyc(NOP, 0, 0, 1, 2'b00, '0);
        cyc(NOP, 0, 0, 1, 2'b11, '0); cyc(NOP, 0, 0, 1, 2'b00, '0); idle(5);

        // R5 R6: suspend during read and write
        phase = "R5 R6";
        cas_lat3 = 1;
        cyc(RD, 4, 0, 1, '0, '0); cyc(NOP, 0, 0, 0, '0, '0); cyc(NOP, 0, 0, 0, 2'b11, '0);
        cyc(NOP, 0, 0, 1, '0, '0); cyc(NOP, 0, 0, 0, '0, '0); idle(6);
        cyc(WR, 9, 0, 0, '0, 16'h1111); cyc(WR, 9, 0, 1, '0, 16'h2222);
        cyc(NOP, 0, 0, 1, '0, 16'h3333); cyc(NOP, 0, 0, 0, '0, 16'h4444);
        cyc(NOP, 0, 0, 1, '0, 16'h5555); cyc(NOP, 0, 0, 1, '0, 16'h6666); idle(2);
        cyc(RD, 8, 0, 1, '0, '0); idle(6);

        // R3 R10: page bursts across the column wrap, stopped
        phase = "R3 R10";
        cas_lat3 = 0;
        cyc(WR, 14, 1, 1, '0, 16'h0E0E);
        for (int i = 1; i < 6; i++) cyc(NOP, 0, 0, 1, '0, 16'(i * 16'h1101));
        cyc(STP, 0, 0, 1, '0, 16'hFFFF); idle(3);
        cyc(RD, 13, 1, 1, '0, '0); idle(6);
        cyc(STP, 0, 0, 1, '0, '0); idle(5);
        phase = "R10 interrupt";
        cyc(RD, 0, 0, 1, '0, '0); cyc(NOP, 0, 0, 1, '0, '0);
        cyc(RD, 9, 0, 1, '0, '0); idle(6);

        // sweep latency x clock-enable x mask patterns
        for (int cl = 0; cl < 2; cl++) begin
            for (int p = 0; p < 4; p++) begin
                phase = "R4 R5 R6 R7 R8 sweep";
                cas_lat3 = cl[0];
                for (int i = 0; i < 8; i++)
                    cyc(i == 0 ? WR : NOP, 4 * p + 1, 0, ((i + p) % 5) != 2,
                        LN'((i * (p + 1) + 1) % 4), 16'((p << 12) + i * 16'h0305 + 16'h1000));
                idle(2);
                for (int i = 0; i < 10; i++)
                    cyc(i == 0 ? RD : NOP, 4 * p + 2, 0, ((i + p) % 4) != 3,
                        LN'((i + p) % 3), '0);
                idle(6);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule